// File: doc/BRIEF.md
# Paired-Priority External Interrupt Controller

This block collects eight external interrupt lines, grouped into four pairs (A, B, C, D), each pair holding a sub-channel 0 and a sub-channel 1. Every line has a pending flag and an enable flag. Every pair has a two-bit software priority field. Software reaches all three registers through a byte-wide read/write port. Each cycle the block picks the most urgent request that is pending, unmasked and allowed by a global enable. It presents that request on a registered request flag together with the winning channel index.

The effective level of a channel is three bits wide. The pair's two programmed bits form the upper part. The sub-channel number supplies the least significant bit. Level 0 is the most urgent. When the CPU services an interrupt it returns the channel index on the acknowledge port, and the block clears that one pending flag. Edge detection is not part of this block: a one-cycle trigger strobe per channel marks each event.

Top module: `irq_pair_ctrl`

## Requirements
- R1: After reset the pending register reads 00h, the enable register reads 00h, the priority register reads FFh and irqReq is 0.
- R2: regSel selects the register: 0 = pending, 1 = enable, 2 = priority, 3 = unused (reads 00h, writes ignored). regRdData follows regSel in the same cycle and a read changes no state. A write with regWrEn is taken at the rising clock edge.
- R3: Channel index i = 2*pair + sub, with pair A=0, B=1, C=2, D=3. Bit i of the pending and enable registers belongs to channel i. A one-cycle trigStrobe[i] sets pending bit i at the next edge.
- R4: A software write to the pending register loads the written byte. Writing 1 raises a software interrupt and writing 0 cancels a pending one.
- R5: ackValid with ackIdx = i clears pending bit i only. All other pending bits keep their value.
- R6: If a trigger or a software write of 1 reaches the same bit in the same cycle as its acknowledge, the bit stays set.
- R7: A channel can request only when its pending bit, its enable bit and globalEn are all 1. With no eligible channel, irqReq is 0 and irqIdx is 0.
- R8: Priority register bits [2p+1:2p] are the upper two level bits of pair p. The level of channel i is {prio[2p+1], prio[2p], i[0]}. The lowest level wins.
- R9: irqReq and irqIdx are registered. A change to pending, enable, priority or globalEn appears on them one clock edge after it takes effect.
- R10: When two channels share a level, the lower channel index wins. This can happen between sub-channel-0 lines of different pairs that have equal priority fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| trigStrobe | input | 8 | One-cycle trigger event per channel |
| globalEn | input | 1 | Global interrupt enable |
| regSel | input | 2 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| ackValid | input | 1 | Acknowledge strobe |
| ackIdx | input | 3 | Index of the serviced channel |
| irqReq | output | 1 | Registered request flag |
| irqIdx | output | 3 | Registered winning channel index |

## Verification
Two events can fall on the same pending bit in one cycle: the acknowledge clear, and a set from either a hardware trigger or a software write of 1. The bench first sets a bit. It then drives the acknowledge for that bit in the same cycle as a trigger strobe, and separately in the same cycle as a pending write with that bit at 1. A neighbouring bit is acknowledged alone as a control. Each result is judged by reading the pending register back through the register port: the contended bit must remain 1 and the control bit must be 0.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
  parameter int NUM_PAIRS = 4;
  localparam int NUM_CH   = 2 * NUM_PAIRS;
  localparam int IDX_W    = $clog2(NUM_CH);
  localparam int DATA_W   = NUM_CH;
  localparam int PRIO_W   = 2 * NUM_PAIRS;
  localparam int LVL_W    = 3;
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PEND = 2'd0,
    SEL_MASK = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             pendWr;
    logic             maskWr;
    logic             prioWr;
    logic             ackValid;
    logic [IDX_W-1:0] ackIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_pair_decode.sv
module irq_pair_decode
  import irq_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] regSel,
  input  logic             regWrEn,
  input  logic             ackValid,
  input  logic [IDX_W-1:0] ackIdx,
  output ctrlStrobes_t     strobes
);
  always_comb begin
    strobes          = '0;
    strobes.ackValid = ackValid;
    strobes.ackIdx   = ackIdx;
    if (regWrEn) begin
      case (regSel_e'(regSel))
        SEL_PEND: strobes.pendWr = 1'b1;
        SEL_MASK: strobes.maskWr = 1'b1;
        SEL_PRIO: strobes.prioWr = 1'b1;
        default:  ;
      endcase
    end
  end

  // R2: at most one register is written per cycle; unused select writes nothing
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.pendWr, strobes.maskWr, strobes.prioWr}));
  assert_unused_sel_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_NONE) |-> !(strobes.pendWr || strobes.maskWr || strobes.prioWr));
endmodule

// File: rtl/irq_pair_regs.sv
module irq_pair_regs
  import irq_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [NUM_CH-1:0] trigStrobe,
  output logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] mask,
  output logic [PRIO_W-1:0] prio,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_CH-1:0] ackVec;
  logic [NUM_CH-1:0] swBase;
  logic [NUM_CH-1:0] swSet;
  logic [NUM_CH-1:0] pendNext;

  always_comb begin
    ackVec   = strobes.ackValid ? (NUM_CH'(1) << strobes.ackIdx) : '0;
    swBase   = strobes.pendWr ? wrData[NUM_CH-1:0] : pending;
    swSet    = strobes.pendWr ? wrData[NUM_CH-1:0] : '0;
    pendNext = (swBase & ~ackVec) | swSet | trigStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      mask    <= '0;
      prio    <= '1;
    end else begin
      pending <= pendNext;
      if (strobes.maskWr) mask <= wrData[NUM_CH-1:0];
      if (strobes.prioWr) prio <= wrData[PRIO_W-1:0];
    end
  end

  always_comb begin
    case (regSel_e'(regSel))
      SEL_PEND: rdData = DATA_W'(pending);
      SEL_MASK: rdData = DATA_W'(mask);
      SEL_PRIO: rdData = DATA_W'(prio);
      default:  rdData = '0;
    endcase
  end

  // R3: every strobed channel is pending after the edge
  assert_trig_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trigStrobe != '0) |=> ((pending & $past(trigStrobe)) == $past(trigStrobe)));
  // R5: an uncontested acknowledge leaves its bit cleared
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackValid && !trigStrobe[strobes.ackIdx]
     && !(strobes.pendWr && wrData[strobes.ackIdx]))
    |=> (((pending >> $past(strobes.ackIdx)) & NUM_CH'(1)) == '0));
  // R5: bits untouched by any source keep their value
  assert_ack_isolated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackValid && !strobes.pendWr && trigStrobe == '0)
    |=> ((pending | (NUM_CH'(1) << $past(strobes.ackIdx)))
         == ($past(pending) | (NUM_CH'(1) << $past(strobes.ackIdx)))));
  // R1: priority register idles until written
  assert_prio_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.prioWr |=> $stable(prio));
endmodule

// File: rtl/irq_pair_arb.sv
module irq_pair_arb
  import irq_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pending,
  input  logic [NUM_CH-1:0] mask,
  input  logic [PRIO_W-1:0] prio,
  input  logic              globalEn,
  output logic              irqReq,
  output logic [IDX_W-1:0]  irqIdx
);
  logic [NUM_CH-1:0] eligible;
  logic [LVL_W-1:0]  chLvl [NUM_CH];
  logic              found;
  logic [LVL_W-1:0]  bestLvl;
  logic [IDX_W-1:0]  bestIdx;

  assign eligible = pending & mask & {NUM_CH{globalEn}};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
    localparam int PAIR = g / 2;
    localparam logic SUB = ((g % 2) == 1);
    assign chLvl[g] = {prio[2*PAIR+1], prio[2*PAIR], SUB};
  end

  always_comb begin
    found   = 1'b0;
    bestLvl = '1;
    bestIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (eligible[i] && (!found || chLvl[i] < bestLvl)) begin
        found   = 1'b1;
        bestLvl = chLvl[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      irqIdx <= '0;
    end else begin
      irqReq <= found;
      irqIdx <= bestIdx;
    end
  end

  // R7: global disable suppresses the request on the next cycle
  assert_global_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !irqReq);
  // R7: a granted channel was eligible when chosen
  assert_grant_eligible_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((($past(eligible) >> irqIdx) & NUM_CH'(1)) != '0));
  // R9: any eligible channel yields a request one edge later
  assert_req_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eligible != '0) |=> irqReq);
  // R7: no request implies index zero
  assert_idle_idx_R7: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqIdx == '0));
endmodule

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl
  import irq_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] trigStrobe,
  input  logic              globalEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackIdx,
  output logic              irqReq,
  output logic [IDX_W-1:0]  irqIdx
);
  ctrlStrobes_t      strobes;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] mask;
  logic [PRIO_W-1:0] prio;

  irq_pair_decode u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .regSel  (regSel),
    .regWrEn (regWrEn),
    .ackValid(ackValid),
    .ackIdx  (ackIdx),
    .strobes (strobes)
  );

  irq_pair_regs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .regSel    (regSel),
    .trigStrobe(trigStrobe),
    .pending   (pending),
    .mask      (mask),
    .prio      (prio),
    .rdData    (regRdData)
  );

  irq_pair_arb u_arb (
    .clk     (clk),
    .rstN    (rstN),
    .pending (pending),
    .mask    (mask),
    .prio    (prio),
    .globalEn(globalEn),
    .irqReq  (irqReq),
    .irqIdx  (irqIdx)
  );
endmodule

// File: tb/test_irq_pair_ctrl.sv
module test_irq_pair_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] trigStrobe = '0;
  logic       globalEn = 1'b0;
  logic [1:0] regSel = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       ackValid = 1'b0;
  logic [2:0] ackIdx = '0;
  logic       irqReq;
  logic [2:0] irqIdx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_pair_ctrl i_irq_pair_ctrl (
    .clk(clk), .rstN(rstN), .trigStrobe(trigStrobe), .globalEn(globalEn),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ackValid(ackValid), .ackIdx(ackIdx),
    .irqReq(irqReq), .irqIdx(irqIdx)
  );

  // {mask, prio, pending, globalEn, expReq, expIdx}
  localparam int NV = 8;
  localparam logic [28:0] VECS [NV] = '{
    {8'hFF, 8'hFF, 8'h81, 1'b1, 1'b1, 3'd0},
    {8'hFF, 8'h00, 8'hA0, 1'b1, 1'b1, 3'd5},
    {8'h7F, 8'h3F, 8'hC1, 1'b1, 1'b1, 3'd6},
    {8'hFF, 8'h1B, 8'h0A, 1'b1, 1'b1, 3'd3},
    {8'hFF, 8'h1B, 8'h0A, 1'b0, 1'b0, 3'd0},
    {8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0, 3'd0},
    {8'hFF, 8'hE4, 8'h3C, 1'b1, 1'b1, 3'd2},
    {8'hF7, 8'hE4, 8'h28, 1'b1, 1'b1, 3'd5}
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [7:0] d);
    regSel = sel;
    #0.5;
    d = regRdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] rd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(2'd0, rd); check("R1", "pending reset", rd, 8'h00);
    rdReg(2'd1, rd); check("R1", "mask reset", rd, 8'h00);
    rdReg(2'd2, rd); check("R1", "prio reset", rd, 8'hFF);
    check("R1", "irqReq reset", {7'd0, irqReq}, 8'h00);

    // R10 tie at reset priorities: B0 and C0 both level 6
    globalEn = 1'b1;
    wrReg(2'd1, 8'hFF);
    wrReg(2'd0, 8'h14);
    @(negedge clk);
    check("R10", "tie req", {7'd0, irqReq}, 8'h01);
    check("R10", "tie idx", {5'd0, irqIdx}, 8'h02);

    // R8/R7 vector table
    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VECS[v];
      globalEn = e[4];
      wrReg(2'd1, e[28:21]);
      wrReg(2'd2, e[20:13]);
      wrReg(2'd0, e[12:5]);
      @(negedge clk);
      rdReg(2'd1, rd); check("R2", "mask readback", rd, e[28:21]);
      rdReg(2'd2, rd); check("R2", "prio readback", rd, e[20:13]);
      check("R7", "vector req", {7'd0, irqReq}, {7'd0, e[3]});
      check("R8", "vector idx", {5'd0, irqIdx}, {5'd0, e[2:0]});
    end

    // R4 software write 0 cancels, R2 unused select
    wrReg(2'd0, 8'h00);
    rdReg(2'd0, rd); check("R4", "sw clear", rd, 8'h00);
    wrReg(2'd3, 8'h5A);
    rdReg(2'd3, rd); check("R2", "unused reads zero", rd, 8'h00);
    rdReg(2'd0, rd); rdReg(2'd0, rd2);
    check("R2", "unused write no effect / read stable", rd2, 8'h00);

    // R3 trigger on C0 (bit 4) and C1 (bit 5)
    wrReg(2'd1, 8'h00);
    @(negedge clk);
    trigStrobe = 8'h30;
    @(negedge clk);
    trigStrobe = 8'h00;
    rdReg(2'd0, rd); check("R3", "trigger sets C0 C1", rd, 8'h30);

    // R5 acknowledge clears only its bit
    ackValid = 1'b1; ackIdx = 3'd4;
    @(negedge clk);
    ackValid = 1'b0;
    rdReg(2'd0, rd); check("R5", "ack clears only bit4", rd, 8'h20);

    // R6 trigger and ack on bit5 in same cycle
    ackValid = 1'b1; ackIdx = 3'd5; trigStrobe = 8'h20;
    @(negedge clk);
    ackValid = 1'b0; trigStrobe = 8'h00;
    rdReg(2'd0, rd); check("R6", "trig beats ack", rd, 8'h20);

    // R6 software write of 1 with ack on bit5; bit1 acknowledged-free control
    regSel = 2'd0; regWrData = 8'h22; regWrEn = 1'b1;
    ackValid = 1'b1; ackIdx = 3'd5;
    @(negedge clk);
    regWrEn = 1'b0; ackValid = 1'b0;
    rdReg(2'd0, rd); check("R6", "sw set beats ack", rd, 8'h22);
    ackValid = 1'b1; ackIdx = 3'd1;
    @(negedge clk);
    ackValid = 1'b0;
    rdReg(2'd0, rd); check("R5", "control ack bit1", rd, 8'h20);

    // R9 mask write becomes visible one edge after it lands
    wrReg(2'd1, 8'h20);
    check("R9", "req not yet", {7'd0, irqReq}, 8'h00);
    @(negedge clk);
    check("R9", "req after one edge", {7'd0, irqReq}, 8'h01);
    check("R9", "idx after one edge", {5'd0, irqIdx}, 8'h05);

    // R7 global disable
    globalEn = 1'b0;
    @(negedge clk);
    check("R7", "global off", {7'd0, irqReq}, 8'h00);
    check("R7", "idle idx", {5'd0, irqIdx}, 8'h00);

    finishRun();
  end
endmodule